// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a shared two-port storage array and decides which of the two access ports may write when both point at the same word at the same time. Each port presents an enable, an address and a write request. When both ports are enabled on one address, the port that reached that address first keeps the location. The port that came later is flagged busy, and its write qualifier is withheld for as long as the overlap lasts.

Arrival is measured in clock cycles. A port "arrives" in the cycle when it becomes enabled or changes its address. If both ports arrive in the same cycle, the left port is favoured. The decision is registered and held for the whole overlap, so the outcome cannot flip while the two addresses keep matching.

A mode input lets several arbiters serve one wider word. In master mode the block computes busy itself and drives it out. In slave mode its own busy outputs stay low, and busy inputs taken from a master gate the write qualifiers instead. Reads are never blocked; only writes are qualified.

Top module: `dpc_arbiter`

## Requirements
- R1: After reset, with both ports idle, both busy outputs and both write qualifiers are 0.
- R2: Busy is never raised unless both enables are 1 and the two addresses are equal.
- R3: On a match, the port whose enable/address combination became valid in an earlier cycle keeps access, and only the other port's busy output is 1 (master mode).
- R4: When both ports arrive in the same cycle, or both change to a new common address in the same cycle, the right port gets busy. The two busy outputs are never 1 together.
- R5: While the match persists and neither port changes its enable or address, busy stays on the same side, whatever the write requests do.
- R6: Busy falls in the same cycle as the addresses stop matching or either enable drops.
- R7: In master mode a port's write qualifier equals enable AND write request AND NOT its own busy output.
- R8: In slave mode (mode input 0) both busy outputs are 0, and a port's write qualifier equals enable AND write request AND NOT that port's external busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = compute busy locally, 0 = take busy from inputs |
| left_en | input | 1 | Left port enable |
| left_addr | input | AW | Left port word address |
| left_wr | input | 1 | Left port write request |
| right_en | input | 1 | Right port enable |
| right_addr | input | AW | Right port word address |
| right_wr | input | 1 | Right port write request |
| left_busy_in | input | 1 | External busy for the left port (slave mode) |
| right_busy_in | input | 1 | External busy for the right port (slave mode) |
| left_busy_out | output | 1 | Left port lost contention (master mode) |
| right_busy_out | output | 1 | Right port lost contention (master mode) |
| left_wr_ok | output | 1 | Left write may complete |
| right_wr_ok | output | 1 | Right write may complete |

## Verification
All four outputs are settled in the same cycle as the inputs that cause them. The only history involved is the previous cycle's enable and address per port and the held owner, both updated at the rising edge. The bench therefore drives stimulus 1 ns after a rising edge and compares every output on the following falling edge, every cycle, against a model. That model keeps a per-port "arrival cycle" stamp rather than a previous-value register. Scenarios cover each arrival order, the simultaneous case and releases through both the address and the enable.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Winner of a freshly started overlap: a port that has just arrived loses
  // to one that was already there; a same-cycle arrival favours the left.
  function automatic owner_e pick_side(input logic l_new, input logic r_new);
    return (l_new && !r_new) ? OWN_RIGHT : OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          arrived
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  // Port arrives this cycle: newly enabled, or enabled on a new address.
  assign arrived = en && (!en_q || (addr != addr_q));
endmodule

// File: rtl/dpc_grant.sv
module dpc_grant
  import dpc_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          l_new,
  input  logic          r_new,
  output logic          hit,
  output logic          l_lose,
  output logic          r_lose
);
  owner_e owner_q, owner_cur;
  logic   start;

  assign hit   = l_en && r_en && (l_addr == r_addr);
  // A new overlap begins when none is held or when either side has moved.
  assign start = hit && ((owner_q == OWN_NONE) || l_new || r_new);

  always_comb begin
    owner_cur = owner_q;
    if (start) owner_cur = pick_side(l_new, r_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= hit ? owner_cur : OWN_NONE;
  end

  assign l_lose = hit && (owner_cur == OWN_RIGHT);
  assign r_lose = hit && (owner_cur == OWN_LEFT);
endmodule

// File: rtl/dpc_wr_gate.sv
module dpc_wr_gate (
  input  logic is_master,
  input  logic en,
  input  logic wr,
  input  logic arb_lose,
  input  logic ext_busy,
  output logic busy_o,
  output logic wr_ok
);
  logic block;
  assign busy_o = is_master && arb_lose;
  assign block  = is_master ? arb_lose : ext_busy;
  assign wr_ok  = en && wr && !block;
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          left_en,
  input  logic [AW-1:0] left_addr,
  input  logic          left_wr,
  input  logic          right_en,
  input  logic [AW-1:0] right_addr,
  input  logic          right_wr,
  input  logic          left_busy_in,
  input  logic          right_busy_in,
  output logic          left_busy_out,
  output logic          right_busy_out,
  output logic          left_wr_ok,
  output logic          right_wr_ok
);
  localparam int NP = 2; // index 0 = left, 1 = right

  logic [NP-1:0] en_v, wr_v, xb_v, new_v, lose_v, busy_v, ok_v;
  logic [AW-1:0] addr_v [NP];
  logic          hit;

  assign en_v      = {right_en, left_en};
  assign wr_v      = {right_wr, left_wr};
  assign xb_v      = {right_busy_in, left_busy_in};
  assign addr_v[0] = left_addr;
  assign addr_v[1] = right_addr;

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpc_port_track #(.AW(AW)) u_trk (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .addr(addr_v[p]),
      .arrived(new_v[p])
    );
    dpc_wr_gate u_gate (
      .is_master(is_master), .en(en_v[p]), .wr(wr_v[p]),
      .arb_lose(lose_v[p]), .ext_busy(xb_v[p]),
      .busy_o(busy_v[p]), .wr_ok(ok_v[p])
    );
  end

  dpc_grant #(.AW(AW)) u_grant (
    .clk(clk), .rst_n(rst_n),
    .l_en(left_en), .l_addr(left_addr),
    .r_en(right_en), .r_addr(right_addr),
    .l_new(new_v[0]), .r_new(new_v[1]),
    .hit(hit), .l_lose(lose_v[0]), .r_lose(lose_v[1])
  );

  assign left_busy_out  = busy_v[0];
  assign right_busy_out = busy_v[1];
  assign left_wr_ok     = ok_v[0];
  assign right_wr_ok    = ok_v[1];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_master,
  input logic          left_en,
  input logic [AW-1:0] left_addr,
  input logic          left_wr,
  input logic          right_en,
  input logic [AW-1:0] right_addr,
  input logic          right_wr,
  input logic          left_busy_out,
  input logic          right_busy_out,
  input logic          left_wr_ok,
  input logic          right_wr_ok,
  input logic          hit
);
  // R2: busy only on a genuine same-address overlap
  a_r2_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (left_busy_out || right_busy_out) |-> (left_en && right_en && left_addr == right_addr));

  // R4: never both sides busy
  a_r4_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_busy_out && right_busy_out));

  // R4/R3: in master mode an overlap always produces exactly one busy
  a_r3_one_loser_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && hit) |-> $onehot({left_busy_out, right_busy_out}));

  // R5: an undisturbed overlap keeps the same loser
  a_r5_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && left_busy_out) |=>
      (!(is_master && hit && $stable(left_addr) && $stable(right_addr)) || left_busy_out));
  a_r5_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && right_busy_out) |=>
      (!(is_master && hit && $stable(left_addr) && $stable(right_addr)) || right_busy_out));

  // R6: no busy once the overlap is gone
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!left_busy_out && !right_busy_out));

  // R7: a busy port's write never qualifies
  a_r7_block_left: assert property (@(posedge clk) disable iff (!rst_n)
    left_busy_out |-> !left_wr_ok);
  a_r7_block_right: assert property (@(posedge clk) disable iff (!rst_n)
    right_busy_out |-> !right_wr_ok);

  // R8: slave mode never drives busy
  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!left_busy_out && !right_busy_out));
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master),
  .left_en(left_en), .left_addr(left_addr), .left_wr(left_wr),
  .right_en(right_en), .right_addr(right_addr), .right_wr(right_wr),
  .left_busy_out(left_busy_out), .right_busy_out(right_busy_out),
  .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok), .hit(hit)
);

// File: tb/tb_dpc_arbiter.sv
`timescale 1ns/1ps
module tb_dpc_arbiter;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic le = 1'b0, lw = 1'b0, re = 1'b0, rw = 1'b0, lbi = 1'b0, rbi = 1'b0;
  logic [AW-1:0] la = '0, ra = '0;
  logic lbo, rbo, lok, rok;

  int tests = 0, fails = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // model state: arrival stamps and previous-cycle inputs
  int l_stamp = 0, r_stamp = 0;
  logic p_le = 1'b0, p_re = 1'b0;
  logic [AW-1:0] p_la = '0, p_ra = '0;

  always #2.5 clk = ~clk; // 200 MHz

  dpc_arbiter #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .left_en(le), .left_addr(la), .left_wr(lw),
    .right_en(re), .right_addr(ra), .right_wr(rw),
    .left_busy_in(lbi), .right_busy_in(rbi),
    .left_busy_out(lbo), .right_busy_out(rbo),
    .left_wr_ok(lok), .right_wr_ok(rok)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model, compared on every falling edge.
  always @(negedge clk) begin
    logic hitm, lose_l, lose_r, e_lb, e_rb, e_lok, e_rok;
    if (rst_n && !done) begin
      if (le && (!p_le || la != p_la)) l_stamp = cyc;
      if (re && (!p_re || ra != p_ra)) r_stamp = cyc;
      hitm   = le && re && (la == ra);
      lose_l = hitm && (r_stamp < l_stamp);
      lose_r = hitm && !(r_stamp < l_stamp);
      e_lb   = is_master && lose_l;
      e_rb   = is_master && lose_r;
      e_lok  = le && lw && !(is_master ? e_lb : lbi);
      e_rok  = re && rw && !(is_master ? e_rb : rbi);
      tests++;
      if ({lbo, rbo, lok, rok} !== {e_lb, e_rb, e_lok, e_rok}) begin
        fails++;
        $display("FAIL %s cycle %0d: {lbusy,rbusy,lok,rok} actual %b%b%b%b expected %b%b%b%b",
                 cur_req, cyc, lbo, rbo, lok, rok, e_lb, e_rb, e_lok, e_rok);
      end
    end
    p_le = rst_n ? le : 1'b0;
    p_re = rst_n ? re : 1'b0;
    p_la = rst_n ? la : '0;
    p_ra = rst_n ? ra : '0;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_l(input logic e, input logic [AW-1:0] a, input logic w);
    le = e; la = a; lw = w;
  endtask

  task automatic set_r(input logic e, input logic [AW-1:0] a, input logic w);
    re = e; ra = a; rw = w;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    // R1: idle after reset
    cur_req = "R1";
    tick(3);

    // R2: enabled on different addresses, or only one enabled
    cur_req = "R2";
    set_l(1, 14'h0010, 1); set_r(1, 14'h0011, 1); tick(3);
    set_r(0, 14'h0010, 1); tick(2);

    // R3: left holds, right arrives later -> right busy, write blocked (R7)
    cur_req = "R3";
    set_r(1, 14'h0010, 1); tick(3);
    // R6: right moves away -> release in the same cycle
    cur_req = "R6";
    set_r(1, 14'h0020, 1); tick(2);
    // R3: right holds 0x20, left arrives later -> left busy
    cur_req = "R3";
    set_l(1, 14'h0020, 1); tick(3);
    // R6: right enable drops -> release
    cur_req = "R6";
    set_r(0, 14'h0020, 0); tick(2);
    set_l(0, 14'h0000, 0); tick(2);

    // R4: same-cycle arrival -> right busy
    cur_req = "R4";
    set_l(1, 14'h3FFE, 1); set_r(1, 14'h3FFE, 1); tick(3);
    // R4: both move together to a new common address
    set_l(1, 14'h0005, 1); set_r(1, 14'h0005, 1); tick(2);
    set_l(0, 14'h0, 0); set_r(0, 14'h0, 0); tick(2);

    // R5: right first, left later, then write requests toggle
    cur_req = "R5";
    set_r(1, 14'h0007, 0); tick(2);
    set_l(1, 14'h0007, 1); tick(1);
    for (int k = 0; k < 6; k++) begin
      lw = k[0]; rw = ~k[0];
      tick(1);
    end

    // R7: master gating with reads by the busy side still untouched
    cur_req = "R7";
    lw = 0; rw = 1; tick(2);
    set_r(1, 14'h0008, 1); tick(2);

    // R8: slave mode, contention present but busy comes from inputs
    cur_req = "R8";
    is_master = 0;
    set_l(1, 14'h0030, 1); set_r(1, 14'h0030, 1); tick(2);
    lbi = 1; tick(2);
    lbi = 0; rbi = 1; tick(2);
    rbi = 0; lw = 0; tick(2);
    // back to master mode mid-overlap: still one loser
    cur_req = "R4";
    is_master = 1; tick(3);
    set_l(0, 14'h0, 0); set_r(0, 14'h0, 0); tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule